// File: doc/BRIEF.md
# Up/Down Timer-Counter with Prescaler

This block is a 16-bit counter that gives a shared time base to capture and compare channels. A small control register selects whether the counter runs and which way it counts. It also selects whether counts come from a divided internal tick or from an external clock pin, whether the direction comes from a control bit or from an external direction pin, and the ratio of the internal divider.

Software can load the count at any time. A compare channel can clear it with a one-cycle request. The current count is always visible on the output. Separate one-cycle flags report an upward wrap and a downward wrap. Both external pins pass through a two-stage synchronizer before use, and only rising edges of the external clock are counted.

Top module: `updn_timer`

## Requirements
- R1: After reset the count is 0000h, both wrap flags are low and the control register is cleared, so the count stays at 0000h until the control register is written.
- R2: With control bit 0 (enable) at 0, the count holds its value whatever the clock and direction inputs do.
- R3: With enable=1, bit 2 (clock select)=0 and prescale field bits 6:4 = 0, the count changes by one on every clock edge after the control write.
- R4: With prescale field N, the internal tick fires once every 2^N cycles. A control write restarts the divider, so after k edges the count has moved by floor(k / 2^N).
- R5: With bit 3 (direction select)=0, bit 1 gives the direction: 1 counts up and 0 counts down, and the count wraps modulo 2^16.
- R6: With bit 2=1, the internal tick is ignored and each rising edge of the external clock pin moves the count by one. The new count appears on the third clock edge after the pin rises.
- R7: With bit 3=1, the direction comes from the external direction pin (1 = up) after a two-stage synchronizer, and bit 1 is ignored. A pin change first affects the step made at the third clock edge after it.
- R8: The overflow output is high for exactly the one cycle after a counting step from FFFFh to 0000h.
- R9: The underflow output is high for exactly the one cycle after a counting step from 0000h to FFFFh.
- R10: A compare reset request clears the count at the next edge, wins over counting in that cycle, and raises no wrap flag.
- R11: A count write loads the written value at the next edge and wins over both counting and a compare reset in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 7 | Control value: bit0 enable, bit1 up, bit2 external clock, bit3 external direction, bits6:4 prescale |
| cntWe | input | 1 | Count write strobe |
| cntWdata | input | 16 | Value to load into the count |
| cmpReset | input | 1 | One-cycle clear request from a compare match |
| extClk | input | 1 | External count clock pin (asynchronous) |
| extDir | input | 1 | External direction pin, 1 = up (asynchronous) |
| count | output | 16 | Current count |
| overflow | output | 1 | One-cycle pulse on an upward wrap |
| underflow | output | 1 | One-cycle pulse on a downward wrap |

## Verification
Writes, clears and internal steps register in one stage, so their results are due at the first edge after the strobe. Wrap flags appear together with the wrapped count. An external clock rise costs two synchronizer edges and then one counting edge, so the count changes on the third edge. A direction pin change steers the step that lands on the third edge. The bench drives inputs and samples outputs only at falling edges, and counts falling edges after each stimulus so that every check lands in exactly the cycle in which its result is due.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_UP_BIT  = 1;
  localparam int CTRL_CLK_BIT = 2;
  localparam int CTRL_DIR_BIT = 3;
  localparam int CTRL_PS_LSB  = 4;

  typedef struct packed {
    logic step;
    logic up;
    logic load;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/updn_timer_ctrl.sv
module updn_timer_ctrl
  import updn_timer_pkg::*;
#(
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W     = CTRL_PS_LSB + PS_W,
  localparam int DIV_W      = (1 << PS_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              cntWe,
  input  logic              cmpReset,
  input  logic              extClk,
  input  logic              extDir,
  output strobe_t           stb
);
  logic [CTRL_W-1:0] ctrlReg;
  logic              enable, upBit, clkSel, dirSel;
  logic [PS_W-1:0]   psSel;
  logic [1:0]        pinRaw, pinSync;
  logic              clkPrev, extRise;
  logic [DIV_W-1:0]  divCnt, divMask;
  logic              intTick;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctrlWe) ctrlReg <= ctrlWdata;
  end

  assign enable = ctrlReg[CTRL_EN_BIT];
  assign upBit  = ctrlReg[CTRL_UP_BIT];
  assign clkSel = ctrlReg[CTRL_CLK_BIT];
  assign dirSel = ctrlReg[CTRL_DIR_BIT];
  assign psSel  = ctrlReg[CTRL_PS_LSB +: PS_W];

  assign pinRaw = {extDir, extClk};

  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else chain <= {chain[SYNC_STAGES-2:0], pinRaw[g]};
    end
    assign pinSync[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) clkPrev <= 1'b0;
    else clkPrev <= pinSync[0];
  end
  assign extRise = pinSync[0] & ~clkPrev;

  always_ff @(posedge clk) begin
    if (!rstN || ctrlWe || !enable) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    divMask = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < int'(psSel)) divMask[i] = 1'b1;
    end
  end
  assign intTick = ((divCnt & divMask) == divMask);

  always_comb begin
    stb.step  = enable & (clkSel ? extRise : intTick);
    stb.up    = dirSel ? pinSync[1] : upBit;
    stb.load  = cntWe;
    stb.clear = cmpReset;
  end

  // R3: undivided internal tick steps in every cycle
  a_r3_every_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !clkSel && psSel == '0 && !ctrlWe) |=> stb.step);

  // R6: an external edge yields a single isolated step
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (enable && clkSel && stb.step && !ctrlWe) |=> !stb.step);

  // R2: disabled timer never steps
  a_r2_no_step: assert property (@(posedge clk) disable iff (!rstN)
    (!enable) |-> !stb.step);
endmodule

// File: rtl/updn_timer_dp.sv
module updn_timer_dp
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] cntWdata,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
      if (stb.load) begin
        count <= cntWdata;
      end else if (stb.clear) begin
        count <= '0;
      end else if (stb.step) begin
        if (stb.up) begin
          count    <= count + 1'b1;
          overflow <= (count == CNT_MAX);
        end else begin
          count     <= count - 1'b1;
          underflow <= (count == '0);
        end
      end
    end
  end

  // R11: a write lands at the next edge
  a_r11_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> count == $past(cntWdata));

  // R10: a compare reset clears without a wrap flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clear && !stb.load) |=> (count == '0 && !overflow && !underflow));

  // R8: overflow only on an upward wrap
  a_r8_overflow_wrap: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (count == '0 && $past(count) == CNT_MAX));

  // R9: underflow only on a downward wrap
  a_r9_underflow_wrap: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> (count == CNT_MAX && $past(count) == '0));

  // R8 R9: the two flags never coincide
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(overflow && underflow));

  // R2: without any strobe the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.clear && !stb.step) |=> $stable(count));
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W     = CTRL_PS_LSB + PS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              cntWe,
  input  logic [CNT_W-1:0]  cntWdata,
  input  logic              cmpReset,
  input  logic              extClk,
  input  logic              extDir,
  output logic [CNT_W-1:0]  count,
  output logic              overflow,
  output logic              underflow
);
  strobe_t stb;

  updn_timer_ctrl #(.PS_W(PS_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .cntWe(cntWe), .cmpReset(cmpReset), .extClk(extClk), .extDir(extDir),
    .stb(stb)
  );

  updn_timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntWdata(cntWdata),
    .count(count), .overflow(overflow), .underflow(underflow)
  );
endmodule

// File: tb/updn_timer_test.sv
module updn_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [6:0]  ctrlWdata = '0;
  logic        cntWe = 1'b0;
  logic [15:0] cntWdata = '0;
  logic        cmpReset = 1'b0;
  logic        extClk = 1'b0;
  logic        extDir = 1'b0;
  logic [15:0] count;
  logic        overflow, underflow;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  updn_timer uut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .cntWe(cntWe), .cntWdata(cntWdata), .cmpReset(cmpReset),
    .extClk(extClk), .extDir(extDir),
    .count(count), .overflow(overflow), .underflow(underflow)
  );

  // ctrl: bit0 en, bit1 up, bit2 ext clk, bit3 ext dir, bits6:4 prescale
  localparam int NVEC = 8;
  localparam logic [6:0]  V_CTRL  [NVEC] = '{7'h03, 7'h13, 7'h33, 7'h73, 7'h01, 7'h21, 7'h02, 7'h03};
  localparam logic [15:0] V_START [NVEC] = '{16'd0, 16'd100, 16'd0, 16'd5, 16'd50, 16'd3, 16'd1234, 16'hFFF0};
  localparam int          V_CYC   [NVEC] = '{10, 9, 40, 300, 20, 16, 25, 32};
  localparam logic [15:0] V_EXP   [NVEC] = '{16'd10, 16'd104, 16'd5, 16'd7, 16'd30, 16'hFFFF, 16'd1234, 16'h0010};

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Load start and control together; returns at the falling edge after that edge
  task automatic setup(input logic [15:0] start, input logic [6:0] ctrl);
    @(negedge clk);
    cntWe = 1'b1; cntWdata = start; ctrlWe = 1'b1; ctrlWdata = ctrl;
    @(negedge clk);
    cntWe = 1'b0; ctrlWe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state and idle until configured
    check("R1 count after reset", count, 16'h0000);
    check("R1 flags after reset", {14'd0, overflow, underflow}, 16'h0000);
    repeat (20) @(negedge clk);
    check("R1 idle without control write", count, 16'h0000);

    // Vector table: R3 R4 R5 R2 R8 R9 in internal-clock modes
    for (int i = 0; i < NVEC; i++) begin
      setup(V_START[i], V_CTRL[i]);
      repeat (V_CYC[i]) @(negedge clk);
      check($sformatf("R3 R4 R5 R2 vector %0d", i), count, V_EXP[i]);
    end

    // R8: overflow pulse timing
    setup(16'hFFFE, 7'h03);
    @(negedge clk);
    check("R8 before wrap count", count, 16'hFFFF);
    check("R8 before wrap flag", {15'd0, overflow}, 16'd0);
    @(negedge clk);
    check("R8 wrap count", count, 16'h0000);
    check("R8 wrap flag", {15'd0, overflow}, 16'd1);
    @(negedge clk);
    check("R8 flag one cycle", {15'd0, overflow}, 16'd0);

    // R9: underflow pulse timing
    setup(16'h0001, 7'h01);
    @(negedge clk);
    check("R9 before wrap flag", {15'd0, underflow}, 16'd0);
    @(negedge clk);
    check("R9 wrap count", count, 16'hFFFF);
    check("R9 wrap flag", {15'd0, underflow}, 16'd1);
    @(negedge clk);
    check("R9 flag one cycle", {15'd0, underflow}, 16'd0);
    check("R9 count after", count, 16'hFFFE);

    // R10: compare reset at FFFF wins over the step, no flag
    setup(16'hFFFF, 7'h03);
    cmpReset = 1'b1;
    @(negedge clk);
    cmpReset = 1'b0;
    check("R10 cleared", count, 16'h0000);
    check("R10 no overflow", {15'd0, overflow}, 16'd0);
    @(negedge clk);
    check("R10 resumes", count, 16'h0001);

    // R11: write beats compare reset and counting
    setup(16'h0100, 7'h03);
    cmpReset = 1'b1; cntWe = 1'b1; cntWdata = 16'hABCD;
    @(negedge clk);
    cmpReset = 1'b0; cntWe = 1'b0;
    check("R11 write wins", count, 16'hABCD);
    @(negedge clk);
    check("R11 counts from written", count, 16'hABCE);

    // R6: external clock
    extClk = 1'b0;
    setup(16'h0000, 7'h07);
    repeat (10) @(negedge clk);
    check("R6 internal tick ignored", count, 16'h0000);
    extClk = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 not yet after two edges", count, 16'h0000);
    @(negedge clk);
    check("R6 step on third edge", count, 16'h0001);
    repeat (5) @(negedge clk);
    check("R6 level high no extra step", count, 16'h0001);
    extClk = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 falling edge ignored", count, 16'h0001);
    extClk = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 second rise", count, 16'h0002);
    extClk = 1'b0;

    // R7: external direction, bit1 = 0 is ignored
    extDir = 1'b1;
    repeat (3) @(negedge clk);
    setup(16'd10, 7'h09);
    repeat (5) @(negedge clk);
    check("R7 pin up", count, 16'd15);
    extDir = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 old direction for two edges", count, 16'd17);
    repeat (2) @(negedge clk);
    check("R7 pin down", count, 16'd15);

    // R2: disable mid-run holds count while pins toggle
    setup(16'h2222, 7'h02);
    extClk = 1'b1;
    repeat (6) @(negedge clk);
    extClk = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 disabled hold", count, 16'h2222);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule